// File: doc/BRIEF.md
# Cascadable Display-Row Data Capture

This block gathers one row of segment data for a dot-matrix display driver. Words arrive on a parallel bus that is either 4 or 8 bits wide, and the falling edge of a shift clock samples each one. A capture pointer moves across the row one nibble slot at a time, or two slots at a time in the wide mode. It writes every bus word into the next free slice of a 320-bit staging register. The line latch that follows this block reads that register.

Several identical blocks can be chained through a pair of enable pins, and each pin can act as an input or an output. A block that is idle waits in standby until its enable input goes low. It then takes one wake-up edge and captures from the edge after that. One bus word before its row is complete, it pulls its enable output low, so the next block in the chain wakes up in time to take the following word. Once the final word is written, the block goes back to standby without outside help. A direction input mirrors the whole row and swaps which of the two pins is the input.

Top module: `display_row_capture`

## Requirements
- R1: A synchronous active-high reset clears the staging register and puts the block in standby, with its enable output driven high.
- R2: With `wide_bus` = 0, each falling shift-clock edge in capture stores `bus_d[3:0]`, and `bus_d[7:4]` has no effect. Eighty words fill the row.
- R3: With `wide_bus` = 1, each falling edge in capture stores all of `bus_d[7:0]`. Forty words fill the row, and the slot pointer never goes past its last position.
- R4: In standby, a falling edge that sees the enable input low moves the block to capture without storing the bus. Words are stored from the next edge onward. Edges that see the enable input high change nothing.
- R5: The enable output is low only after the edge that stores the second-to-last word, which is 316 bits into the row in narrow mode and 312 bits in wide mode. It returns high on the edge that stores the final word.
- R6: After the final word the block returns to standby without outside help. The staging register then holds its value through any further edges that see the enable input high.
- R7: With `dir_rev` = 0, pin A is the enable input and pin B drives the enable output (`chain_b_oe` = 1, `chain_a_oe` = 0). The row is filled from `row_bits[0]` upward, and the first bit of each word is its most significant bus bit (D3 in narrow mode, D7 in wide mode).
- R8: With `dir_rev` = 1, pin B is the enable input and pin A drives the enable output. Captured bit number p (counting from 0) lands in `row_bits[319-p]`, so the row and the bit order inside each word are mirrored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Data shift clock; bus sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_d | input | 8 | Display data bus |
| wide_bus | input | 1 | 1 = 8-bit capture, 0 = 4-bit capture |
| dir_rev | input | 1 | Row direction and enable pin role select |
| chain_a_i | input | 1 | Pin A sensed level |
| chain_a_o | output | 1 | Pin A driven level |
| chain_a_oe | output | 1 | Pin A output enable |
| chain_b_i | input | 1 | Pin B sensed level |
| chain_b_o | output | 1 | Pin B driven level |
| chain_b_oe | output | 1 | Pin B output enable |
| row_bits | output | 320 | Staging register, bit i feeds segment output i+1 |

## Verification
On every edge the assertions check that the pointer stays in range, that an enabled standby edge wakes the block, and that a disabled standby edge leaves it idle. They also check that the low pulse on the enable output lasts exactly one word and ends in standby, and that the row does not change while nothing is being written. Only the bench scenarios can show that the stored bits land in the right positions for both bus widths and both directions. The scenarios also show that the upper bus nibble is ignored in narrow mode, that the wake-up edge's data is discarded, and that the unselected enable pin has no influence.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} cap_state_e;

  function automatic logic [3:0] rev4(input logic [3:0] n);
    return {n[0], n[1], n[2], n[3]};
  endfunction
endpackage

// File: rtl/drc_sequencer.sv
module drc_sequencer
  import drc_pkg::*;
#(
  parameter int NSLOT = 80,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          en_in,
  output logic          wr_en,
  output logic [PW-1:0] ptr,
  output logic          en_out
);
  localparam logic [PW-1:0] LAST = PW'(NSLOT);

  cap_state_e    state_q;
  logic [PW-1:0] ptr_q;
  logic          en_out_q;
  logic [PW-1:0] step;
  logic [PW-1:0] nxt;

  always_comb begin
    step = wide ? PW'(2) : PW'(1);
    nxt  = ptr_q + step;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      en_out_q <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          en_out_q <= 1'b1;
          if (!en_in) state_q <= ST_FILL;
        end
        default: begin
          if (nxt >= LAST) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            en_out_q <= 1'b1;
          end else begin
            ptr_q    <= nxt;
            en_out_q <= !(nxt == LAST - step);
          end
        end
      endcase
    end
  end

  assign wr_en  = (state_q == ST_FILL);
  assign ptr    = ptr_q;
  assign en_out = en_out_q;

  AST_PTR_RANGE: assert property (@(negedge clk) disable iff (rst)
    ptr_q < LAST); // R3
  AST_WAKE_ON_ENABLE: assert property (@(negedge clk) disable iff (rst)
    (state_q == ST_IDLE && !en_in) |=> (state_q == ST_FILL)); // R4
  AST_IDLE_WHEN_DISABLED: assert property (@(negedge clk) disable iff (rst)
    (state_q == ST_IDLE && en_in) |=> (state_q == ST_IDLE)); // R6
  AST_HANDOFF_ONE_WORD: assert property (@(negedge clk) disable iff (rst)
    !en_out_q |=> (en_out_q && state_q == ST_IDLE)); // R5
endmodule

// File: rtl/drc_slice_store.sv
module drc_slice_store
  import drc_pkg::*;
#(
  parameter int ROW   = 320,
  parameter int NSLOT = 80,
  parameter int PW    = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wide,
  input  logic           rev,
  input  logic [PW-1:0]  ptr,
  input  logic [7:0]     bus_d,
  output logic [ROW-1:0] row
);
  logic [PW-1:0] ptr_lo;
  logic [3:0]    nib_hi_phys;
  logic [3:0]    nib_lo_phys;

  always_comb begin
    ptr_lo      = ptr + PW'(1);
    nib_hi_phys = rev ? bus_d[7:4] : rev4(bus_d[7:4]);
    nib_lo_phys = rev ? bus_d[3:0] : rev4(bus_d[3:0]);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [PW-1:0] FWD = PW'(s);
    localparam logic [PW-1:0] BWD = PW'(NSLOT - 1 - s);
    logic [PW-1:0] lslot;
    logic          hit_hi;
    logic          hit_lo;
    logic [3:0]    cell_q;

    always_comb begin
      lslot  = rev ? BWD : FWD;
      hit_hi = wide && (lslot == ptr);
      hit_lo = wide ? (lslot == ptr_lo) : (lslot == ptr);
    end

    always_ff @(negedge clk) begin
      if (rst)                 cell_q <= '0;
      else if (wr_en && hit_hi) cell_q <= nib_hi_phys;
      else if (wr_en && hit_lo) cell_q <= nib_lo_phys;
    end

    assign row[s*4 +: 4] = cell_q;
  end

  AST_ROW_HOLD: assert property (@(negedge clk) disable iff (rst)
    !wr_en |=> $stable(row)); // R6
endmodule

// File: rtl/drc_chain_pins.sv
module drc_chain_pins (
  input  logic rev,
  input  logic a_i,
  input  logic b_i,
  input  logic en_out,
  output logic en_in,
  output logic a_o,
  output logic a_oe,
  output logic b_o,
  output logic b_oe
);
  always_comb begin
    en_in = rev ? b_i : a_i;
    a_o   = en_out;
    b_o   = en_out;
    a_oe  = rev;
    b_oe  = !rev;
  end
endmodule

// File: rtl/display_row_capture.sv
module display_row_capture #(
  parameter int ROW = 320
) (
  input  logic           shift_clk,
  input  logic           rst,
  input  logic [7:0]     bus_d,
  input  logic           wide_bus,
  input  logic           dir_rev,
  input  logic           chain_a_i,
  output logic           chain_a_o,
  output logic           chain_a_oe,
  input  logic           chain_b_i,
  output logic           chain_b_o,
  output logic           chain_b_oe,
  output logic [ROW-1:0] row_bits
);
  localparam int NSLOT = ROW / 4;
  localparam int PW    = $clog2(NSLOT + 2);

  logic          en_in;
  logic          en_out;
  logic          wr_en;
  logic [PW-1:0] ptr;

  drc_chain_pins u_pins (
    .rev(dir_rev), .a_i(chain_a_i), .b_i(chain_b_i), .en_out(en_out),
    .en_in(en_in), .a_o(chain_a_o), .a_oe(chain_a_oe),
    .b_o(chain_b_o), .b_oe(chain_b_oe)
  );

  drc_sequencer #(.NSLOT(NSLOT), .PW(PW)) u_seq (
    .clk(shift_clk), .rst(rst), .wide(wide_bus), .en_in(en_in),
    .wr_en(wr_en), .ptr(ptr), .en_out(en_out)
  );

  drc_slice_store #(.ROW(ROW), .NSLOT(NSLOT), .PW(PW)) u_store (
    .clk(shift_clk), .rst(rst), .wr_en(wr_en), .wide(wide_bus),
    .rev(dir_rev), .ptr(ptr), .bus_d(bus_d), .row(row_bits)
  );
endmodule

// File: tb/sim_display_row_capture.sv
module sim_display_row_capture;
  localparam int CLK_PERIOD = 10;
  localparam int ROW = 320;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     bus_d = '0;
  logic           wide_bus = 1'b0;
  logic           dir_rev = 1'b0;
  logic           chain_a_i = 1'b1;
  logic           chain_b_i = 1'b1;
  logic           chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [ROW-1:0] row_bits;

  int tests = 0;
  int fails = 0;
  logic [ROW-1:0] model_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  display_row_capture #(.ROW(ROW)) u0 (
    .shift_clk(clk), .rst(rst), .bus_d(bus_d), .wide_bus(wide_bus),
    .dir_rev(dir_rev), .chain_a_i(chain_a_i), .chain_a_o(chain_a_o),
    .chain_a_oe(chain_a_oe), .chain_b_i(chain_b_i), .chain_b_o(chain_b_o),
    .chain_b_oe(chain_b_oe), .row_bits(row_bits)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ROW-1:0] act, input logic [ROW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic edge_step();
    @(negedge clk);
    @(posedge clk);
  endtask

  task automatic set_en(input bit v);
    if (dir_rev) begin chain_b_i = v; chain_a_i = 1'b0; end
    else         begin chain_a_i = v; chain_b_i = 1'b0; end
  endtask

  function automatic logic en_out_pin();
    return dir_rev ? chain_a_o : chain_b_o;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    edge_step(); edge_step();
    rst = 1'b0;
    model_row = '0;
    check(row_bits == '0, "R1", "row cleared", row_bits, '0);
    check(chain_a_o && chain_b_o, "R1", "enable out high",
          ROW'({chain_a_o, chain_b_o}), ROW'(2'b11));
  endtask

  task automatic t_row(input bit wide, input bit rev, input int seed);
    int nwords;
    int w;
    int p;
    bit en_ok;
    logic [7:0] d;
    wide_bus = wide;
    dir_rev  = rev;
    set_en(1'b1);
    nwords = wide ? 40 : 80;
    w      = wide ? 8 : 4;
    // R4: disabled standby edges change nothing, unselected pin held low
    for (int i = 0; i < 3; i++) begin bus_d = 8'h5A ^ 8'(i); edge_step(); end
    check(row_bits == model_row, "R4", "disabled edges ignored", row_bits, model_row);
    check(rev ? (chain_a_oe && !chain_b_oe) : (chain_b_oe && !chain_a_oe),
          rev ? "R8" : "R7", "pin roles",
          ROW'({chain_a_oe, chain_b_oe}), ROW'(rev ? 2'b10 : 2'b01));
    // R4: wake edge, its data must be dropped
    set_en(1'b0);
    bus_d = 8'hFF;
    edge_step();
    set_en(1'b1);
    check(row_bits == model_row, "R4", "wake edge stores nothing", row_bits, model_row);
    p = 0;
    en_ok = 1'b1;
    for (int k = 0; k < nwords; k++) begin
      d = 8'(seed + k * 29);
      if (!wide) d[7:4] = ~d[3:0] ^ 4'h6; // R2: upper nibble is noise
      bus_d = d;
      edge_step();
      for (int j = 0; j < w; j++) begin
        model_row[rev ? ROW - 1 - p : p] = d[w - 1 - j];
        p++;
      end
      if (en_out_pin() !== ((k == nwords - 2) ? 1'b0 : 1'b1)) begin
        en_ok = 1'b0;
        $display("FAIL R5 enable out at word %0d: actual %0b expected %0b",
                 k + 1, en_out_pin(), (k == nwords - 2) ? 1'b0 : 1'b1);
      end
    end
    check(en_ok, "R5", "early hand-off timing", ROW'(en_ok), ROW'(1));
    check(row_bits == model_row, wide ? "R3" : "R2", "row contents", row_bits, model_row);
    check(row_bits[rev ? ROW - 1 : 0] == model_row[rev ? ROW - 1 : 0],
          rev ? "R8" : "R7", "first bit position",
          ROW'(row_bits[rev ? ROW - 1 : 0]), ROW'(model_row[rev ? ROW - 1 : 0]));
    // R6: back in standby, more edges leave the row alone
    for (int i = 0; i < 4; i++) begin bus_d = 8'hC3 + 8'(i); edge_step(); end
    check(row_bits == model_row, "R6", "standby after full row", row_bits, model_row);
    check(en_out_pin() == 1'b1, "R6", "enable out high in standby",
          ROW'(en_out_pin()), ROW'(1));
  endtask

  task automatic t_midrow_reset();
    wide_bus = 1'b1;
    dir_rev  = 1'b0;
    set_en(1'b0);
    edge_step();
    set_en(1'b1);
    for (int k = 0; k < 10; k++) begin bus_d = 8'h81 + 8'(k); edge_step(); end
    rst = 1'b1;
    edge_step();
    rst = 1'b0;
    model_row = '0;
    check(row_bits == '0, "R1", "mid-row reset clears row", row_bits, '0);
    bus_d = 8'hEE;
    edge_step(); edge_step();
    check(row_bits == '0, "R1", "standby after reset", row_bits, '0);
    check(chain_b_o == 1'b1, "R1", "enable out high after reset",
          ROW'(chain_b_o), ROW'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(posedge clk);
    t_reset();
    t_row(1'b0, 1'b0, 17);   // R2 R7
    t_row(1'b1, 1'b0, 101);  // R3 R7
    t_row(1'b0, 1'b1, 55);   // R2 R8
    t_row(1'b1, 1'b1, 200);  // R3 R8
    t_midrow_reset();
    t_row(1'b0, 1'b0, 3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule